// File: doc/BRIEF.md
# ISA I/O Slave Address Decoder and Byte-Lane Steering

This block is the host-side front end of a peripheral that sits on an ISA-style I/O bus and claims a window of 32 byte addresses. It compares the upper address bits with five strap inputs, qualified by the active-low address-enable, and produces a chip select and a 5-bit register index for the register file behind it. The register index comes from the low five address bits only.

Read data from the register file is steered onto the lower or upper byte lane of the 16-bit host bus. The choice depends on the host width (a narrow-host input), the active-low high-byte enable and address bit 0. One index is special: a wide host with the high-byte enable asserted reaches two FIFOs at once, one on each lane. On the write side the block captures the data and the lane routing while the write strobe is low. It hands one commit pulse to the register file after the strobe rises.

The block drives the active-low 16-bit acknowledge for accesses that use the upper lane. For registers marked slow, it also drives a ready pull-down that stretches the host cycle for a fixed number of clocks. Both outputs are open-drain on the pad and are modelled here as drive enables.

Top module: `isa_slave_front`

## Requirements
- R1: `sel_o` is 1 exactly when `aen_ni` is 0 and `addr_i[9:5]` equals `strap_i`. `reg_idx_o` always equals `addr_i[4:0]`, whatever `narrow_i` and `hbe_ni` show.
- R2: The decoded base address is `strap_i` times 32. For example, `strap_i`=5'b10110 claims 0x2C0 to 0x2DF, and every strap value 0 to 31 selects its own window.
- R3: With `narrow_i`=1 and `hbe_ni`=1, every index, odd or even, uses the lower lane `[7:0]` only. With `narrow_i`=1 and `hbe_ni`=0 the access is illegal.
- R4: With `narrow_i`=0, an odd index with `hbe_ni`=0 uses the upper lane `[15:8]` only, and an even index with `hbe_ni`=1 uses the lower lane only.
- R5: With `narrow_i`=0, `hbe_ni`=0 and index 5'h18 (`PAIR_IDX`), the access is paired and `pair_o` is 1. A read returns `fifo_hi_rdata_i` on `[15:8]` and `reg_rdata_i` on `[7:0]`. A write commits `bus_wdata_i[7:0]` as `wr_data_o` and `bus_wdata_i[15:8]` as `wr_pair_data_o`, with `wr_pair_o`=1.
- R6: Any other combination with `narrow_i`=0 (an even non-pair index with `hbe_ni`=0, or an odd index with `hbe_ni`=1) is illegal. An illegal access enables no lane, holds `cs16_no` at 1, commits no write and never pulls ready.
- R7: `cs16_no` is 0 exactly while the chip is selected for a legal access that uses the upper lane. It depends on the address phase alone, not on a strobe.
- R8: `lo_oe_o` and `hi_oe_o` are 1 only while `rd_ni` is 0 for a selected, legal access on that lane. `bus_rdata_o` is 0 on any lane whose enable is 0.
- R9: When `wr_ni` is sampled 1 at a clock edge after being sampled 0 at the previous edge, `wr_commit_o` is 1 for exactly the next cycle. That happens only if the access sampled during the low phase was selected and legal. The pulse carries the captured index, and `wr_data_o` is the byte from the lane in use (`[15:8]` for an upper-lane-only write).
- R10: When a strobe is first sampled low for a selected, legal access whose index n has `SLOW_MASK[n]`=1 (default: indices 16 to 31), `rdy_pull_o` is 1 for the next `WAIT_CYC` cycles (default 4). The pull drops one cycle after both strobes are sampled high. Fast indices never pull.
- R11: While `rst_ni` is 0, `wr_commit_o` and `rdy_pull_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Host I/O address |
| aen_ni | input | 1 | Address enable, active low |
| strap_i | input | 5 | Base-address straps, compared with addr_i[9:5] |
| narrow_i | input | 1 | 1 = 8-bit host, 0 = 16-bit host |
| hbe_ni | input | 1 | High-byte enable, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bus_wdata_i | input | 16 | Host write data |
| reg_rdata_i | input | 8 | Read byte of the addressed register (FIFO B in paired access) |
| fifo_hi_rdata_i | input | 8 | FIFO A read byte for a paired access |
| sel_o | output | 1 | Chip selected |
| reg_idx_o | output | 5 | Register index |
| pair_o | output | 1 | Selected paired FIFO access |
| bus_rdata_o | output | 16 | Read data toward the host bus |
| lo_oe_o | output | 1 | Lower-lane output enable |
| hi_oe_o | output | 1 | Upper-lane output enable |
| cs16_no | output | 1 | 16-bit acknowledge, active low |
| rdy_pull_o | output | 1 | 1 = pull host ready line low |
| wr_commit_o | output | 1 | One-cycle write commit |
| wr_idx_o | output | 5 | Index of committed write |
| wr_data_o | output | 8 | Byte for the addressed register |
| wr_pair_o | output | 1 | Commit is paired; wr_pair_data_o valid |
| wr_pair_data_o | output | 8 | FIFO A byte of a paired write |

## Verification
The bench sweeps every address against every combination of address-enable, host width and high-byte enable. It catches a decoder that lets the width inputs alter the index, and a lane table that drives a lane or acknowledges 16 bits on an illegal combination. A lane table that confuses odd and even, or drops the paired FIFO index, returns data on the wrong lane in the same sweep. A strap sweep exposes a base comparison that is bit-reversed or uses the wrong slice. Write cycles check that the commit lands one cycle after the strobe rises, carries upper-lane data for odd wide writes, and never fires for illegal or unselected cycles. Ready checks count the stretch on slow indices, confirm that fast and illegal accesses never pull, and show that an early strobe release cancels the stretch instead of leaving the line held.

// File: rtl/isa_front_pkg.sv
package isa_front_pkg;
  typedef struct packed {
    logic legal;
    logic lo;
    logic hi;
  } lane_sel_t;
endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 5,
  localparam int STRAP_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               aen_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sel_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [STRAP_W-1:0] diff;

  // per-bit compare; open strap reads 1 so it matches a 1 address bit
  for (genvar b = 0; b < STRAP_W; b++) begin : g_cmp
    assign diff[b] = addr_i[IDX_W+b] ^ strap_i[b];
  end

  assign sel_o = !aen_ni && (diff == '0);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/isa_lane_decode.sv
module isa_lane_decode
  import isa_front_pkg::*;
#(
  parameter int              IDX_W    = 5,
  parameter logic [IDX_W-1:0] PAIR_IDX = 5'h18
) (
  input  logic             narrow_i,
  input  logic             hbe_ni,
  input  logic [IDX_W-1:0] idx_i,
  output lane_sel_t        lane_o
);
  always_comb begin
    lane_o = '0;
    if (narrow_i) begin
      lane_o.legal = hbe_ni;
      lane_o.lo    = hbe_ni;
    end else if (!hbe_ni && idx_i == PAIR_IDX) begin
      lane_o = '{legal: 1'b1, lo: 1'b1, hi: 1'b1};
    end else if (!hbe_ni && idx_i[0]) begin
      lane_o.legal = 1'b1;
      lane_o.hi    = 1'b1;
    end else if (hbe_ni && !idx_i[0]) begin
      lane_o.legal = 1'b1;
      lane_o.lo    = 1'b1;
    end
  end
endmodule

// File: rtl/isa_wr_capture.sv
module isa_wr_capture
  import isa_front_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int BYTE_W = 8,
  localparam int BUS_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  lane_sel_t         lane_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_ni,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              pair_o,
  output logic [BYTE_W-1:0] pair_data_o
);
  logic              wr_q;
  logic              cap_ok, cap_pair;
  logic [IDX_W-1:0]  cap_idx;
  logic [BYTE_W-1:0] cap_main, cap_upper;
  logic              rise;

  assign rise = !wr_q && wr_ni;

  // latch address phase and data on every low-strobe sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b1;
      cap_ok    <= 1'b0;
      cap_pair  <= 1'b0;
      cap_idx   <= '0;
      cap_main  <= '0;
      cap_upper <= '0;
    end else begin
      wr_q <= wr_ni;
      if (!wr_ni) begin
        cap_ok    <= sel_i && lane_i.legal;
        cap_pair  <= lane_i.lo && lane_i.hi;
        cap_idx   <= idx_i;
        cap_main  <= (lane_i.hi && !lane_i.lo) ? wdata_i[BUS_W-1:BYTE_W]
                                               : wdata_i[BYTE_W-1:0];
        cap_upper <= wdata_i[BUS_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o    <= 1'b0;
      idx_o       <= '0;
      data_o      <= '0;
      pair_o      <= 1'b0;
      pair_data_o <= '0;
    end else begin
      commit_o <= rise && cap_ok;
      pair_o   <= rise && cap_ok && cap_pair;
      if (rise && cap_ok) begin
        idx_o       <= cap_idx;
        data_o      <= cap_main;
        pair_data_o <= cap_upper;
      end
    end
  end
endmodule

// File: rtl/isa_rdy_timer.sv
module isa_rdy_timer #(
  parameter int                 IDX_W     = 5,
  parameter int                 WAIT_CYC  = 4,
  parameter logic [2**IDX_W-1:0] SLOW_MASK = 32'hFFFF_0000,
  localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             pull_o
);
  if (WAIT_CYC == 0) begin : g_none
    assign pull_o = 1'b0;
  end else begin : g_cnt
    logic             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    assign start = strobe_i && !act_q && hit_i && SLOW_MASK[idx_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        act_q <= strobe_i;
        if (start)              cnt_q <= CNT_W'(WAIT_CYC);
        else if (!strobe_i)     cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
    end

    assign pull_o = (cnt_q != '0);
  end
endmodule

// File: rtl/isa_slave_front.sv
module isa_slave_front
  import isa_front_pkg::*;
#(
  parameter int                 ADDR_W    = 10,
  parameter int                 IDX_W     = 5,
  parameter int                 BYTE_W    = 8,
  parameter logic [IDX_W-1:0]   PAIR_IDX  = 5'h18,
  parameter int                 WAIT_CYC  = 4,
  parameter logic [2**IDX_W-1:0] SLOW_MASK = 32'hFFFF_0000,
  localparam int STRAP_W = ADDR_W - IDX_W,
  localparam int BUS_W   = 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               aen_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               narrow_i,
  input  logic               hbe_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  input  logic [BYTE_W-1:0]  reg_rdata_i,
  input  logic [BYTE_W-1:0]  fifo_hi_rdata_i,
  output logic               sel_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  output logic               pair_o,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               lo_oe_o,
  output logic               hi_oe_o,
  output logic               cs16_no,
  output logic               rdy_pull_o,
  output logic               wr_commit_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_pair_o,
  output logic [BYTE_W-1:0]  wr_pair_data_o
);
  lane_sel_t lane;
  logic      hit;

  isa_addr_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .addr_i (addr_i),
    .aen_ni (aen_ni),
    .strap_i(strap_i),
    .sel_o  (sel_o),
    .idx_o  (reg_idx_o)
  );

  isa_lane_decode #(.IDX_W(IDX_W), .PAIR_IDX(PAIR_IDX)) u_lane (
    .narrow_i(narrow_i),
    .hbe_ni  (hbe_ni),
    .idx_i   (reg_idx_o),
    .lane_o  (lane)
  );

  assign hit     = sel_o && lane.legal;
  assign pair_o  = hit && lane.lo && lane.hi;
  assign cs16_no = !(hit && lane.hi);
  assign lo_oe_o = hit && lane.lo && !rd_ni;
  assign hi_oe_o = hit && lane.hi && !rd_ni;

  always_comb begin
    bus_rdata_o = '0;
    if (lo_oe_o) bus_rdata_o[BYTE_W-1:0] = reg_rdata_i;
    if (hi_oe_o) bus_rdata_o[BUS_W-1:BYTE_W] = lane.lo ? fifo_hi_rdata_i : reg_rdata_i;
  end

  isa_wr_capture #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_o),
    .lane_i     (lane),
    .idx_i      (reg_idx_o),
    .wr_ni      (wr_ni),
    .wdata_i    (bus_wdata_i),
    .commit_o   (wr_commit_o),
    .idx_o      (wr_idx_o),
    .data_o     (wr_data_o),
    .pair_o     (wr_pair_o),
    .pair_data_o(wr_pair_data_o)
  );

  isa_rdy_timer #(.IDX_W(IDX_W), .WAIT_CYC(WAIT_CYC), .SLOW_MASK(SLOW_MASK)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(!rd_ni || !wr_ni),
    .hit_i   (hit),
    .idx_i   (reg_idx_o),
    .pull_o  (rdy_pull_o)
  );
endmodule

// File: rtl/isa_slave_front_chk.sv
module isa_slave_front_chk #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 5,
  parameter logic [IDX_W-1:0] PAIR_IDX = 5'h18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              aen_ni,
  input logic              narrow_i,
  input logic              hbe_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic              sel_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              pair_o,
  input logic              lo_oe_o,
  input logic              hi_oe_o,
  input logic              cs16_no,
  input logic              rdy_pull_o,
  input logic              wr_commit_o,
  input logic              wr_pair_o
);
  assert_sel_aen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> !aen_ni);
  assert_cs16_wide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs16_no |-> sel_o && !narrow_i && !hbe_ni);
  assert_narrow_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_i |-> !hi_oe_o && cs16_no);
  assert_oe_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_oe_o || hi_oe_o) |-> sel_o && !rd_ni);
  assert_pair_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_oe_o && hi_oe_o) |-> pair_o && reg_idx_o == PAIR_IDX && addr_i[IDX_W-1:0] == PAIR_IDX);
  assert_commit_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);
  assert_commit_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(wr_ni) && !$past(wr_ni, 2));
  assert_pair_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pair_o |-> wr_commit_o);
  assert_rdy_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_pull_o |-> $past(!rd_ni || !wr_ni));
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R11: assert (!wr_commit_o && !rdy_pull_o);
  end
endmodule

bind isa_slave_front isa_slave_front_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAIR_IDX(PAIR_IDX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .aen_ni     (aen_ni),
  .narrow_i   (narrow_i),
  .hbe_ni     (hbe_ni),
  .rd_ni      (rd_ni),
  .wr_ni      (wr_ni),
  .sel_o      (sel_o),
  .reg_idx_o  (reg_idx_o),
  .pair_o     (pair_o),
  .lo_oe_o    (lo_oe_o),
  .hi_oe_o    (hi_oe_o),
  .cs16_no    (cs16_no),
  .rdy_pull_o (rdy_pull_o),
  .wr_commit_o(wr_commit_o),
  .wr_pair_o  (wr_pair_o)
);

// File: tb/isa_slave_front_test.sv
module isa_slave_front_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  addr = '0;
  logic        aen_ni = 1'b1;
  logic [4:0]  strap = 5'b10110;
  logic        narrow = 1'b0;
  logic        hbe_ni = 1'b1;
  logic        rd_ni = 1'b1;
  logic        wr_ni = 1'b1;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata = '0;
  logic [7:0]  fdata = '0;
  logic        sel, pair, lo_oe, hi_oe, cs16_n, rdy_pull, commit, wpair;
  logic [4:0]  idx, widx;
  logic [15:0] brd;
  logic [7:0]  wd, wpd;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  isa_slave_front uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .aen_ni(aen_ni), .strap_i(strap),
    .narrow_i(narrow), .hbe_ni(hbe_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .bus_wdata_i(wdata), .reg_rdata_i(rdata), .fifo_hi_rdata_i(fdata),
    .sel_o(sel), .reg_idx_o(idx), .pair_o(pair), .bus_rdata_o(brd),
    .lo_oe_o(lo_oe), .hi_oe_o(hi_oe), .cs16_no(cs16_n), .rdy_pull_o(rdy_pull),
    .wr_commit_o(commit), .wr_idx_o(widx), .wr_data_o(wd), .wr_pair_o(wpair),
    .wr_pair_data_o(wpd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected lane use {legal, lo, hi} from the requirement table
  function automatic logic [2:0] exp_lane(input logic nar, input logic hbe_n, input logic [4:0] ix);
    if (nar) return hbe_n ? 3'b110 : 3'b000;
    if (!hbe_n && ix == 5'h18) return 3'b111;
    if (!hbe_n && ix[0]) return 3'b101;
    if (hbe_n && !ix[0]) return 3'b110;
    return 3'b000;
  endfunction

  task automatic do_write(input logic [9:0] a, input logic nar, input logic hbe_n,
                          input logic [15:0] d, input logic exp_c, input logic [7:0] exp_d,
                          input logic exp_p, input string tag);
    @(negedge clk);
    addr = a; narrow = nar; hbe_ni = hbe_n; wdata = d; aen_ni = 1'b0; wr_ni = 1'b0;
    repeat (3) @(negedge clk);
    wr_ni = 1'b1;
    @(negedge clk);
    chk({tag, " commit"}, commit, exp_c);
    if (exp_c) begin
      chk({tag, " idx"}, widx, a[4:0]);
      chk({tag, " data"}, wd, exp_d);
      chk({tag, " pair"}, wpair, exp_p);
      if (exp_p) chk({tag, " pair data"}, wpd, d[15:8]);
    end
    @(negedge clk);
    chk({tag, " single pulse"}, commit, 1'b0);
    aen_ni = 1'b1;
  endtask

  task automatic do_rdy(input logic [9:0] a, input logic nar, input logic hbe_n,
                        input int exp_n, input string tag);
    int seen = 0;
    @(negedge clk);
    addr = a; narrow = nar; hbe_ni = hbe_n; aen_ni = 1'b0; rd_ni = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk({tag, " pull cycle"}, rdy_pull, (k < exp_n) ? 1'b1 : 1'b0);
      if (rdy_pull) seen++;
    end
    chk({tag, " pull count"}, seen, exp_n);
    rd_ni = 1'b1;
    @(negedge clk);
    chk({tag, " released"}, rdy_pull, 1'b0);
    aen_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 commit in reset", commit, 1'b0);
    chk("R11 pull in reset", rdy_pull, 1'b0);
    chk("R11 cs16 idle", cs16_n, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R6 R7 R8: full address sweep under each mode, read strobe low
    for (int a = 0; a < 1024; a++) begin
      for (int m = 0; m < 8; m++) begin
        logic es, eh, el, eoh, eol;
        logic [2:0] ln;
        logic [15:0] ed;
        @(negedge clk);
        addr = 10'(a); aen_ni = m[0]; narrow = m[1]; hbe_ni = m[2];
        rdata = 8'(a) ^ 8'(m * 37); fdata = ~rdata;
        rd_ni = 1'b0;
        #1;
        es  = !m[0] && (a[9:5] == strap);
        ln  = exp_lane(m[1], m[2], a[4:0]);
        el  = es && ln[2] && ln[1];
        eh  = es && ln[2] && ln[0];
        eoh = eh; eol = el;
        ed  = {eoh ? ((ln[1] && ln[0]) ? fdata : rdata) : 8'h00, eol ? rdata : 8'h00};
        chk("R1 sel", sel, es);
        chk("R1 idx", idx, a[4:0]);
        chk("R7 cs16", cs16_n, !eh);
        chk("R8 lo oe", lo_oe, eol);
        chk("R8 hi oe", hi_oe, eoh);
        chk("R5 pair", pair, el && eh);
        chk("R3 R4 R6 rdata", brd, ed);
      end
    end
    // R8: no output enable without read strobe
    @(negedge clk);
    rd_ni = 1'b1; addr = 10'h2D8; aen_ni = 1'b0; narrow = 1'b0; hbe_ni = 1'b0;
    #1;
    chk("R8 no oe without read", {lo_oe, hi_oe, brd}, 18'h0);
    chk("R7 cs16 address phase", cs16_n, 1'b0);
    aen_ni = 1'b1;

    // R2 every strap value picks its own window
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      strap = 5'(s); aen_ni = 1'b0; addr = {5'(s), 5'h07};
      #1;
      chk("R2 strap hit", sel, 1'b1);
      addr = {5'(s) ^ 5'b00001, 5'h07};
      #1;
      chk("R2 strap miss", sel, 1'b0);
    end
    strap = 5'b10110; aen_ni = 1'b1;
    @(negedge clk);
    addr = 10'h2C0; aen_ni = 1'b0;
    #1;
    chk("R2 base 0x2C0", sel, 1'b1);
    addr = 10'h2BF;
    #1;
    chk("R2 below base", sel, 1'b0);
    aen_ni = 1'b1;

    // R9 write commits
    do_write(10'h2C5, 1'b1, 1'b1, 16'hA55A, 1'b1, 8'h5A, 1'b0, "R9 R3 narrow odd");
    do_write(10'h2C4, 1'b0, 1'b1, 16'h1234, 1'b1, 8'h34, 1'b0, "R9 R4 wide even");
    do_write(10'h2C7, 1'b0, 1'b0, 16'hBEEF, 1'b1, 8'hBE, 1'b0, "R9 R4 wide odd upper");
    do_write(10'h2D8, 1'b0, 1'b0, 16'hC3A1, 1'b1, 8'hA1, 1'b1, "R9 R5 paired fifo");
    do_write(10'h2D8, 1'b1, 1'b1, 16'h7788, 1'b1, 8'h88, 1'b0, "R9 R3 narrow 0x18");
    do_write(10'h2C2, 1'b0, 1'b0, 16'hFFFF, 1'b0, 8'h00, 1'b0, "R6 illegal wide even hbe");
    do_write(10'h2C3, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h00, 1'b0, "R6 illegal wide odd no hbe");
    do_write(10'h2C4, 1'b1, 1'b0, 16'hFFFF, 1'b0, 8'h00, 1'b0, "R6 illegal narrow hbe");
    do_write(10'h0C4, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h00, 1'b0, "R9 R1 unselected");

    // R10 ready stretch
    do_rdy(10'h2D4, 1'b0, 1'b1, 4, "R10 slow index");
    do_rdy(10'h2DF, 1'b1, 1'b1, 4, "R10 slow narrow");
    do_rdy(10'h2C4, 1'b0, 1'b1, 0, "R10 fast index");
    do_rdy(10'h2D2, 1'b0, 1'b0, 0, "R10 R6 illegal slow");
    do_rdy(10'h0D4, 1'b0, 1'b1, 0, "R10 unselected");
    // R10 early release cancels stretch
    @(negedge clk);
    addr = 10'h2D4; narrow = 1'b0; hbe_ni = 1'b1; aen_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk);
    chk("R10 write pulls", rdy_pull, 1'b1);
    wr_ni = 1'b1;
    @(negedge clk);
    chk("R10 early release", rdy_pull, 1'b0);
    aen_ni = 1'b1;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule